// File: doc/BRIEF.md
# Bypass Select and Load-Use Interlock Controller

This controller steers operands in a five-stage integer pipeline (fetch, decode, execute, memory, write-back). For each source operand it picks where the value comes from: the register file, the result held in the EX/MEM pipeline register, or the result held in the MEM/WB pipeline register. The same selection covers the ALU operands and the store-data value that a store carries towards the data memory. If an instruction needs a load's result one cycle too early, the controller raises a stall for one cycle. During that cycle the datapath holds the PC and the IF/ID register and loads a no-op into ID/EX.

The operand selects are worked out while the consumer is still in decode, using the destinations held in ID/EX and EX/MEM. They are registered, so they arrive as clean flops in the cycle the consumer reaches execute. A load followed at once by a store that uses the loaded value only as store data does not stall. The controller instead raises a late store-data correction flag when that store reaches the memory stage. The datapath then takes the store data from the MEM/WB result. The register file writes before it reads within a cycle, so a writer three or more slots ahead never needs a bypass.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While reset is high at a clock edge, all registered outputs go low after that edge: both operand selects read 2'b00, and the bubble and late store-data flags read 0.
- R2: When an instruction reaches execute, an operand select reads 2'b10 (EX/MEM source) if the instruction directly ahead of it writes that source register. This holds for the ALU operand A select and for the B select, which also carries the store-data value.
- R3: An operand select reads 2'b01 (MEM/WB source) if the instruction two slots ahead writes the source register and the one directly ahead does not.
- R4: When both the instruction one ahead and the one two ahead write the same source register, the select reads 2'b10, so the newer result wins. The value 2'b11 never appears.
- R5: A source register of 0, a source that the instruction does not use, or a match against an instruction whose write-enable is clear all give select 2'b00.
- R6: A writer three or more slots ahead gives select 2'b00, because the register file already returns the written value.
- R7: The stall output is high, in the same cycle, when ID/EX holds a load with a nonzero destination and a write-enable set, and the decode instruction reads that destination as an ALU source. A store's rs1 counts as an ALU source; its rs2 does not. Instructions that are not loads never cause a stall.
- R8: After a stall cycle, the bubble output is high and both selects read 2'b00 for one cycle. The held instruction enters execute in the next cycle and takes the load result through select 2'b01.
- R9: A load directly followed by a store whose rs2 is the load's destination, and whose rs1 is not, causes no stall. The late store-data flag is high in the cycle that store is in the memory stage, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_ADDR_W | First source register of the decode instruction |
| id_rs2 | input | REG_ADDR_W | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_store | input | 1 | Decode instruction is a store (rs2 is store data) |
| idex_rd | input | REG_ADDR_W | Destination held in ID/EX |
| idex_wen | input | 1 | ID/EX instruction writes a register |
| idex_load | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | REG_ADDR_W | Destination held in EX/MEM |
| exmem_wen | input | 1 | EX/MEM instruction writes a register |
| stall_o | output | 1 | Hold PC and IF/ID, clear ID/EX control this cycle |
| bubble_o | output | 1 | The execute slot holds an injected no-op |
| ex_sel_a | output | 2 | Operand A source for the execute instruction |
| ex_sel_b | output | 2 | Operand B / store-data source for the execute instruction |
| mem_st_fix | output | 1 | Replace store data with the MEM/WB result in the memory stage |

## Verification
The assertions assume that the pipeline around the controller behaves in a fixed way. It advances every stage on every cycle without a stall, and on a stall it clears write-enable and the load flag in ID/EX. The cycle-ahead selects are only meaningful under that behaviour. The stimulus keeps to it by driving every port from a model of four pipeline slots. That model shifts on each edge and, on a stall, keeps the decode instruction in place and puts a cleared slot into execute. Register numbers are drawn from a small range so that matches, double matches and x0 cases come up often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_MEMWB = 2'b01,
    SRC_EXMEM = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/fwd_src_pick.sv
// One operand: compare a decode source against the two destinations that
// will sit in EX/MEM and MEM/WB once the instruction reaches execute.
module fwd_src_pick
  import fwd_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src_rs,
  input  logic          src_use,
  input  logic [RW-1:0] near_rd,
  input  logic          near_wen,
  input  logic [RW-1:0] far_rd,
  input  logic          far_wen,
  output fwd_src_e      src_sel
);
  logic near_hit, far_hit;

  assign near_hit = src_use && near_wen && (near_rd != '0) && (near_rd == src_rs);
  assign far_hit  = src_use && far_wen  && (far_rd  != '0) && (far_rd  == src_rs);

  always_comb begin
    if (near_hit)     src_sel = SRC_EXMEM;
    else if (far_hit) src_sel = SRC_MEMWB;
    else              src_sel = SRC_RF;
  end
endmodule

// File: rtl/hzd_load_detect.sv
// Load-use detection against the instruction in ID/EX.
module hzd_load_detect #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] rs1,
  input  logic [RW-1:0] rs2,
  input  logic          use1,
  input  logic          use2,
  input  logic          is_store,
  input  logic [RW-1:0] ld_rd,
  input  logic          ld_wen,
  input  logic          ld_is_load,
  output logic          stall,
  output logic          st_late
);
  logic ld_live, hit1, hit2;

  assign ld_live = ld_is_load && ld_wen && (ld_rd != '0);
  assign hit1    = use1 && (rs1 == ld_rd);
  assign hit2    = use2 && (rs2 == ld_rd);

  // store data needed only at MEM: no stall, fix it late instead
  assign stall   = ld_live && (hit1 || (hit2 && !is_store));
  assign st_late = ld_live && hit2 && is_store && !hit1;
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import fwd_pkg::*;
#(
  parameter int REG_ADDR_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [REG_ADDR_W-1:0] id_rs1,
  input  logic [REG_ADDR_W-1:0] id_rs2,
  input  logic                  id_use_rs1,
  input  logic                  id_use_rs2,
  input  logic                  id_is_store,
  input  logic [REG_ADDR_W-1:0] idex_rd,
  input  logic                  idex_wen,
  input  logic                  idex_load,
  input  logic [REG_ADDR_W-1:0] exmem_rd,
  input  logic                  exmem_wen,
  output logic                  stall_o,
  output logic                  bubble_o,
  output logic [1:0]            ex_sel_a,
  output logic [1:0]            ex_sel_b,
  output logic                  mem_st_fix
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][REG_ADDR_W-1:0] src_rs;
  logic [NSRC-1:0]                 src_use;
  fwd_src_e                        src_sel [NSRC];
  logic [NSRC-1:0][1:0]            sel_q;
  logic                            st_late;
  logic                            stfix_ex_q;

  assign src_rs[0]  = id_rs1;
  assign src_rs[1]  = id_rs2;
  assign src_use[0] = id_use_rs1;
  assign src_use[1] = id_use_rs2;

  // ID/EX becomes EX/MEM and EX/MEM becomes MEM/WB on the next edge
  for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
    fwd_src_pick #(.RW(REG_ADDR_W)) pick_i (
      .src_rs  (src_rs[gi]),
      .src_use (src_use[gi]),
      .near_rd (idex_rd),
      .near_wen(idex_wen),
      .far_rd  (exmem_rd),
      .far_wen (exmem_wen),
      .src_sel (src_sel[gi])
    );
  end

  hzd_load_detect #(.RW(REG_ADDR_W)) ld_i (
    .rs1       (id_rs1),
    .rs2       (id_rs2),
    .use1      (id_use_rs1),
    .use2      (id_use_rs2),
    .is_store  (id_is_store),
    .ld_rd     (idex_rd),
    .ld_wen    (idex_wen),
    .ld_is_load(idex_load),
    .stall     (stall_o),
    .st_late   (st_late)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q      <= '0;
      bubble_o   <= 1'b0;
      stfix_ex_q <= 1'b0;
      mem_st_fix <= 1'b0;
    end else begin
      mem_st_fix <= stfix_ex_q;
      if (stall_o) begin
        sel_q      <= '0;
        bubble_o   <= 1'b1;
        stfix_ex_q <= 1'b0;
      end else begin
        for (int i = 0; i < NSRC; i++) sel_q[i] <= src_sel[i];
        bubble_o   <= 1'b0;
        stfix_ex_q <= st_late;
      end
    end
  end

  assign ex_sel_a = sel_q[0];
  assign ex_sel_b = sel_q[1];
endmodule

// File: rtl/fwd_hazard_chk.sv
module fwd_hazard_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [RW-1:0] id_rs1,
  input logic [RW-1:0] id_rs2,
  input logic          id_use_rs1,
  input logic          id_use_rs2,
  input logic          id_is_store,
  input logic [RW-1:0] idex_rd,
  input logic          idex_wen,
  input logic          idex_load,
  input logic [RW-1:0] exmem_rd,
  input logic          exmem_wen,
  input logic          stall_o,
  input logic          bubble_o,
  input logic [1:0]    ex_sel_a,
  input logic [1:0]    ex_sel_b,
  input logic          mem_st_fix
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (ex_sel_a == 2'b00 && ex_sel_b == 2'b00 && !bubble_o && !mem_st_fix)); // R1
  AST_NEWEST_WINS: assert property (@(posedge clk) disable iff (rst) (!stall_o && id_use_rs1 && id_rs1 != '0 && idex_wen && idex_rd == id_rs1) |=> ex_sel_a == 2'b10); // R2
  AST_OLDER_SRC: assert property (@(posedge clk) disable iff (rst) (!stall_o && id_use_rs2 && id_rs2 != '0 && !(idex_wen && idex_rd == id_rs2) && exmem_wen && exmem_rd == id_rs2) |=> ex_sel_b == 2'b01); // R3
  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst) (ex_sel_a != 2'b11 && ex_sel_b != 2'b11)); // R4
  AST_X0_NO_FWD: assert property (@(posedge clk) disable iff (rst) (!stall_o && (!id_use_rs1 || id_rs1 == '0)) |=> ex_sel_a == 2'b00); // R5
  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst) stall_o |-> (idex_load && idex_wen && idex_rd != '0)); // R7
  AST_BUBBLE_AFTER_STALL: assert property (@(posedge clk) disable iff (rst) stall_o |=> (bubble_o && ex_sel_a == 2'b00 && ex_sel_b == 2'b00)); // R8
  AST_NO_BUBBLE_WITHOUT_STALL: assert property (@(posedge clk) disable iff (rst) bubble_o |-> $past(stall_o)); // R8
  AST_LATE_STORE_NO_STALL: assert property (@(posedge clk) disable iff (rst) (id_is_store && id_use_rs2 && !id_use_rs1 && idex_load) |-> !stall_o); // R9
  AST_FIX_NOT_AFTER_STALL: assert property (@(posedge clk) disable iff (rst) mem_st_fix |-> !$past(stall_o, 2)); // R9
endmodule

bind fwd_hazard_unit fwd_hazard_chk #(.RW(REG_ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .id_rs1     (id_rs1),
  .id_rs2     (id_rs2),
  .id_use_rs1 (id_use_rs1),
  .id_use_rs2 (id_use_rs2),
  .id_is_store(id_is_store),
  .idex_rd    (idex_rd),
  .idex_wen   (idex_wen),
  .idex_load  (idex_load),
  .exmem_rd   (exmem_rd),
  .exmem_wen  (exmem_wen),
  .stall_o    (stall_o),
  .bubble_o   (bubble_o),
  .ex_sel_a   (ex_sel_a),
  .ex_sel_b   (ex_sel_b),
  .mem_st_fix (mem_st_fix)
);

// File: tb/fwd_hazard_unit_tb_top.sv
module fwd_hazard_unit_tb_top;
  localparam int RW = 5;

  typedef struct packed {
    logic [RW-1:0] rs1;
    logic [RW-1:0] rs2;
    logic          u1;
    logic          u2;
    logic          st;
    logic [RW-1:0] rd;
    logic          wen;
    logic          ld;
    logic          bub;
  } ins_t;

  logic          clk = 1'b0;
  logic          rst;
  logic [RW-1:0] id_rs1, id_rs2, idex_rd, exmem_rd;
  logic          id_use_rs1, id_use_rs2, id_is_store, idex_wen, idex_load, exmem_wen;
  logic          stall_o, bubble_o, mem_st_fix;
  logic [1:0]    ex_sel_a, ex_sel_b;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  ins_t s_id, s_ex, s_mem, s_wb;

  always #10 clk = ~clk;

  fwd_hazard_unit #(.REG_ADDR_W(RW)) dut_i (
    .clk(clk), .rst(rst),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
    .id_is_store(id_is_store), .idex_rd(idex_rd), .idex_wen(idex_wen), .idex_load(idex_load),
    .exmem_rd(exmem_rd), .exmem_wen(exmem_wen), .stall_o(stall_o), .bubble_o(bubble_o),
    .ex_sel_a(ex_sel_a), .ex_sel_b(ex_sel_b), .mem_st_fix(mem_st_fix)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit writes(input ins_t w, input logic [RW-1:0] r);
    return w.wen && (w.rd != '0) && (w.rd == r);
  endfunction

  // expected select of one source of the execute instruction
  task automatic chk_sel(input string what, input logic [RW-1:0] r, input logic u, input int act);
    if (!u || r == '0)                          chk("R5", what, act, 0);
    else if (writes(s_mem, r) && writes(s_wb, r)) chk("R4", what, act, 2);
    else if (writes(s_mem, r))                  chk("R2", what, act, 2);
    else if (writes(s_wb, r))                   chk("R3", what, act, 1);
    else                                        chk("R6", what, act, 0);
  endtask

  function automatic bit exp_stall();
    bit live = s_ex.ld && s_ex.wen && (s_ex.rd != '0);
    bit h1 = s_id.u1 && (s_id.rs1 == s_ex.rd);
    bit h2 = s_id.u2 && (s_id.rs2 == s_ex.rd);
    return live && (h1 || (h2 && !s_id.st));
  endfunction

  function automatic bit exp_fix();
    return s_mem.st && s_mem.u2 && s_wb.ld && writes(s_wb, s_mem.rs2);
  endfunction

  task automatic check_regs();
    chk_sel("ex_sel_a", s_ex.rs1, s_ex.u1, int'(ex_sel_a));
    chk_sel("ex_sel_b", s_ex.rs2, s_ex.u2, int'(ex_sel_b));
    chk("R8", "bubble_o", int'(bubble_o), int'(s_ex.bub));
    chk("R9", "mem_st_fix", int'(mem_st_fix), int'(exp_fix()));
  endtask

  task automatic drive_ports();
    id_rs1 = s_id.rs1; id_rs2 = s_id.rs2; id_use_rs1 = s_id.u1; id_use_rs2 = s_id.u2;
    id_is_store = s_id.st;
    idex_rd = s_ex.rd; idex_wen = s_ex.wen; idex_load = s_ex.ld;
    exmem_rd = s_mem.rd; exmem_wen = s_mem.wen;
  endtask

  // one clock; returns whether the model stalled
  task automatic cycle(input ins_t nxt, output bit stalled);
    ins_t bub;
    @(negedge clk);
    check_regs();
    drive_ports();
    #1;
    stalled = exp_stall();
    chk("R7", "stall_o", int'(stall_o), int'(stalled));
    @(posedge clk);
    s_wb  = s_mem;
    s_mem = s_ex;
    if (stalled) begin
      bub = '0; bub.bub = 1'b1;
      s_ex = bub;
    end else begin
      s_ex = s_id;
      s_id = nxt;
    end
  endtask

  task automatic push(input ins_t nxt);
    bit st;
    do cycle(nxt, st); while (st);
  endtask

  function automatic ins_t mk(input int rs1, input int rs2, input bit u1, input bit u2,
                              input bit st, input int rd, input bit wen, input bit ld);
    ins_t t;
    t.rs1 = RW'(rs1); t.rs2 = RW'(rs2); t.u1 = u1; t.u2 = u2; t.st = st;
    t.rd = RW'(rd); t.wen = wen; t.ld = ld; t.bub = 1'b0;
    return t;
  endfunction

  function automatic ins_t rnd_ins();
    int k = int'($urandom_range(0, 99));
    int a = int'($urandom_range(0, 3));
    int b = int'($urandom_range(0, 3));
    int d = int'($urandom_range(0, 3));
    bit u1 = ($urandom_range(0, 9) != 0);
    bit u2 = ($urandom_range(0, 2) != 0);
    if (k < 20) return mk(a, b, u1, 1'b1, 1'b1, 0, 1'b0, 1'b0);   // store
    if (k < 45) return mk(a, b, u1, 1'b0, 1'b0, d, 1'b1, 1'b1);   // load
    return mk(a, b, u1, u2, 1'b0, d, ($urandom_range(0, 7) != 0), 1'b0);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    ins_t nop = '0;
    void'($urandom(32'h5EED_0042));
    s_id = '0; s_ex = '0; s_mem = '0; s_wb = '0;
    rst = 1'b1;
    drive_ports();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "ex_sel_a reset", int'(ex_sel_a), 0);
    chk("R1", "ex_sel_b reset", int'(ex_sel_b), 0);
    chk("R1", "bubble_o reset", int'(bubble_o), 0);
    chk("R1", "mem_st_fix reset", int'(mem_st_fix), 0);
    rst = 1'b0;

    // directed corners
    push(mk(0, 0, 0, 0, 0, 1, 1, 0));   // write x1
    push(mk(0, 0, 0, 0, 0, 2, 1, 0));   // write x2
    push(mk(1, 2, 1, 1, 0, 3, 1, 0));   // R3 on a, R2 on b
    push(mk(0, 0, 0, 0, 0, 1, 1, 0));
    push(mk(0, 0, 0, 0, 0, 1, 1, 0));
    push(mk(1, 0, 1, 1, 0, 0, 0, 0));   // R4 on a, R5 x0 on b
    push(mk(0, 0, 0, 0, 0, 3, 1, 0));   // write x3
    push(nop);
    push(nop);
    push(mk(3, 3, 1, 1, 0, 0, 0, 0));   // R6 three ahead
    push(mk(1, 0, 0, 0, 0, 2, 1, 1));   // load x2
    push(mk(2, 0, 1, 0, 0, 1, 1, 0));   // R7 stall, R8 bubble then 01
    push(mk(1, 0, 1, 0, 0, 3, 1, 1));   // load x3
    push(mk(1, 3, 1, 1, 1, 0, 0, 0));   // R9 store data fixed late
    push(mk(0, 0, 0, 0, 0, 1, 0, 0));   // write-enable clear
    push(mk(1, 1, 1, 1, 0, 0, 0, 0));   // R5 no match
    push(mk(1, 0, 1, 0, 0, 2, 1, 1));   // load x2
    push(mk(2, 2, 1, 1, 1, 0, 0, 0));   // store uses x2 on rs1: R7 stall

    for (int i = 0; i < 3000; i++) push(rnd_ins());
    for (int i = 0; i < 5; i++) push(nop);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule